// File: doc/BRIEF.md
# Flash Mode-Dependent Read Responder

This block forms the read-side data path of a parallel NOR flash device model. Each cycle it may accept one read strobe with a byte offset and an access size. It looks at the operating mode reported by the command sequencer and returns one of four things: array data, identification words, a status byte whose bit 6 flips on every poll, or a byte from a built-in capability query table. The storage array is outside this block. The block drives its address onto a combinational read port and gets back the four bytes that start at that offset. It then packs them into 1, 2 or 4 byte results, in little- or big-endian lane order.

Results appear one cycle after the strobe, together with a valid flag. Identification and query lookups take their index from the low offset byte, scaled down by the configured bus width. The block also keeps a fast-path hint for the system. The hint is raised once enough back-to-back array reads have been seen in plain read mode since the last write, and any write drops it again.

Top module: `frr_read_resp`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0, `fast_rd` is 1, and the internal status byte is 0x00, so the first status poll returns 0x00.
- R2: `rd_valid` is 1 in the cycle after each accepted strobe (`rd_req`=1) and 0 otherwise, and `rd_data` holds the result from that point on.
- R3: Mode codes 0 (read) and 1 (erase armed) return array data. So do the unused codes 5, 6 and 7. The array address equals `rd_off`.
- R4: Size code 0 returns 1 byte, code 1 returns 2 bytes and codes 2 and 3 return 4 bytes, with the unused upper bytes set to zero. Byte k is the array byte at offset+k, with the offset wrapping at the chip size. With `big_end`=0, byte k is placed at bits 8k+7:8k. With `big_end`=1, byte 0 goes in the most significant used lane.
- R5: In identification mode (code 2), the query index is `rd_off[7:0]` shifted right by log2(BUS_BYTES). Index 0 returns ID0 and index 1 returns ID1, zero-extended. Index 2 returns 0.
- R6: In identification mode, index 0x0E returns ID2 and index 0x0F returns ID3, unless that identifier equals 0x00FF, in which case array data is returned. Every other index returns array data.
- R7: In busy mode (code 3), a read returns {24'h0, status}, and each accepted busy read inverts status bit 6 after it is sampled.
- R8: `st_load` writes `st_din` into the status byte. When a busy read and a load fall in the same cycle, the read returns the old status and the loaded value is kept with no toggle.
- R9: In query mode (code 4), a read returns the table byte at the scaled index. The table holds 0x51 0x52 0x59 at 0x10–0x12, 0x02 and 0x00 at 0x13–0x14, and 0x31 at 0x15. Index 0x27 holds log2 of the chip byte count and 0x2C holds 1. Indices 0x2D and 0x2E hold NUM_SECT−1, low byte then high byte. Indices 0x2F and 0x30 hold bits 15:8 and 23:16 of SECT_BYTES.
- R10: A query-mode index of 0x52 or above returns 0.
- R11: An accepted read in mode 0 while `fast_rd`=0 counts toward the threshold. When the FAST_THRESH-th such read (42 by default) is accepted, `fast_rd` rises in the following cycle. `wr_seen` clears both the count and `fast_rd`, and it takes priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe |
| rd_off | input | OFF_W | Byte offset within the chip |
| rd_size | input | 2 | Access size code |
| big_end | input | 1 | Lane order for multi-byte array reads |
| mode | input | 3 | Current mode from the command sequencer |
| wr_seen | input | 1 | A bus write happened this cycle |
| st_load | input | 1 | Load the status byte |
| st_din | input | 8 | Status value to load |
| arr_addr | output | OFF_W | Array read-port address |
| arr_rdata | input | 32 | Four array bytes starting at `arr_addr` (byte k in bits 8k+7:8k) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| fast_rd | output | 1 | Direct-read fast path permitted |

## Verification
Two events can fall in the same cycle and collide. A status load can land with a busy-mode poll, and a write can land with a read that would be the one to cross the fast-path threshold. The bench creates both collisions on purpose. It then checks that the poll returns the pre-load status, that the next poll returns the loaded value untoggled, and that `fast_rd` is low on the following cycle even though the read itself was served. A behavioural model, kept outside the design, tracks the status byte and the read count, and it is compared on every clock.

// File: rtl/frr_pkg.sv
package frr_pkg;

   typedef enum logic [2:0] {
      MD_ARRAY     = 3'd0,
      MD_ERASE_ARM = 3'd1,
      MD_IDENT     = 3'd2,
      MD_BUSY      = 3'd3,
      MD_QUERY     = 3'd4
   } frr_mode_e;

   typedef enum logic [1:0] {
      SZ_1  = 2'd0,
      SZ_2  = 2'd1,
      SZ_4  = 2'd2,
      SZ_4X = 2'd3
   } frr_size_e;

   localparam logic [7:0] QRY_TABLE_LEN = 8'h52;
   localparam int         TOGGLE_BIT    = 6;
   localparam logic [15:0] ID_ABSENT    = 16'h00FF;

   function automatic int size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_1:    return 1;
         SZ_2:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/frr_lane_pack.sv
module frr_lane_pack #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] raw_i,
   input  logic [1:0]         size_i,
   input  logic               big_end_i,
   output logic [8*LANES-1:0] word_o
);
   import frr_pkg::*;

   int nb;
   always_comb nb = size_bytes(size_i);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         lane_b = 8'h00;
         if (g < nb) begin
            if (big_end_i) lane_b = raw_i[8*(nb-1-g) +: 8];
            else           lane_b = raw_i[8*g +: 8];
         end
      end
      assign word_o[8*g +: 8] = lane_b;
   end

endmodule

// File: rtl/frr_cfi_rom.sv
module frr_cfi_rom #(
   parameter int SECT_BYTES = 512,
   parameter int NUM_SECT   = 8
) (
   input  logic [7:0] idx_i,
   output logic [7:0] byte_o
);
   localparam logic [15:0] SECT_M1   = 16'(NUM_SECT - 1);
   localparam logic [23:0] SECT_SZ   = 24'(SECT_BYTES);
   localparam logic [7:0]  SIZE_LOG2 = 8'($clog2(SECT_BYTES * NUM_SECT));

   always_comb begin
      case (idx_i)
         8'h10: byte_o = 8'h51;
         8'h11: byte_o = 8'h52;
         8'h12: byte_o = 8'h59;
         8'h13: byte_o = 8'h02;
         8'h15: byte_o = 8'h31;
         8'h1B: byte_o = 8'h27;
         8'h1C: byte_o = 8'h36;
         8'h1F: byte_o = 8'h07;
         8'h21: byte_o = 8'h09;
         8'h22: byte_o = 8'h0C;
         8'h23: byte_o = 8'h01;
         8'h25: byte_o = 8'h0A;
         8'h26: byte_o = 8'h0D;
         8'h27: byte_o = SIZE_LOG2;
         8'h28: byte_o = 8'h02;
         8'h2C: byte_o = 8'h01;
         8'h2D: byte_o = SECT_M1[7:0];
         8'h2E: byte_o = SECT_M1[15:8];
         8'h2F: byte_o = SECT_SZ[15:8];
         8'h30: byte_o = SECT_SZ[23:16];
         8'h31: byte_o = 8'h50;
         8'h32: byte_o = 8'h52;
         8'h33: byte_o = 8'h49;
         8'h34: byte_o = 8'h31;
         8'h35: byte_o = 8'h30;
         default: byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/frr_status_tog.sv
module frr_status_tog (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_i,
   input  logic [7:0] din_i,
   input  logic       poll_i,
   output logic [7:0] stat_o
);
   import frr_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)      stat_o <= 8'h00;
      else if (ld_i)   stat_o <= din_i;
      else if (poll_i) stat_o[TOGGLE_BIT] <= ~stat_o[TOGGLE_BIT];
   end

endmodule

// File: rtl/frr_fast_mon.sv
module frr_fast_mon #(
   parameter int THRESH = 42
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic fast_o
);
   localparam int CNT_W = $clog2(THRESH + 1);

   if (THRESH < 1) begin : g_chk_thresh
      $error("frr_fast_mon: THRESH must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fast_o <= 1'b1;
      end else if (clr_i) begin
         cnt_q  <= '0;
         fast_o <= 1'b0;
      end else if (tick_i && !fast_o) begin
         if (cnt_q == CNT_W'(THRESH - 1)) begin
            cnt_q  <= CNT_W'(THRESH);
            fast_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/frr_read_resp.sv
module frr_read_resp #(
   parameter int          BUS_BYTES   = 1,
   parameter int          SECT_BYTES  = 512,
   parameter int          NUM_SECT    = 8,
   parameter logic [15:0] ID0         = 16'h0001,
   parameter logic [15:0] ID1         = 16'h2210,
   parameter logic [15:0] ID2         = 16'h2212,
   parameter logic [15:0] ID3         = 16'h2201,
   parameter int          FAST_THRESH = 42,
   localparam int         OFF_W       = $clog2(SECT_BYTES * NUM_SECT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic [OFF_W-1:0] rd_off,
   input  logic [1:0]       rd_size,
   input  logic             big_end,
   input  logic [2:0]       mode,
   input  logic             wr_seen,
   input  logic             st_load,
   input  logic [7:0]       st_din,
   output logic [OFF_W-1:0] arr_addr,
   input  logic [31:0]      arr_rdata,
   output logic             rd_valid,
   output logic [31:0]      rd_data,
   output logic             fast_rd
);
   import frr_pkg::*;

   localparam int LANES = 4;

   if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)) begin : g_chk_bus
      $error("frr_read_resp: BUS_BYTES must be 1, 2 or 4");
   end
   if (SECT_BYTES < 256 || (SECT_BYTES & (SECT_BYTES - 1)) != 0) begin : g_chk_sect
      $error("frr_read_resp: SECT_BYTES must be a power of two of at least 256");
   end
   if (NUM_SECT < 1 || NUM_SECT > 65536 || (NUM_SECT & (NUM_SECT - 1)) != 0) begin : g_chk_nsect
      $error("frr_read_resp: NUM_SECT must be a power of two from 1 to 65536");
   end

   logic [7:0]  q_idx;
   logic [31:0] arr_word;
   logic [7:0]  cfi_byte;
   logic [7:0]  stat_q;
   logic [31:0] sel_data;
   logic        busy_poll;
   logic        array_tick;

   if (BUS_BYTES == 4) begin : g_idx_x4
      assign q_idx = {2'b00, rd_off[7:2]};
   end else if (BUS_BYTES == 2) begin : g_idx_x2
      assign q_idx = {1'b0, rd_off[7:1]};
   end else begin : g_idx_x1
      assign q_idx = rd_off[7:0];
   end

   assign arr_addr = rd_off;

   frr_lane_pack #(.LANES(LANES)) i_pack (
      .raw_i     (arr_rdata),
      .size_i    (rd_size),
      .big_end_i (big_end),
      .word_o    (arr_word)
   );

   frr_cfi_rom #(.SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT)) i_rom (
      .idx_i  (q_idx),
      .byte_o (cfi_byte)
   );

   assign busy_poll  = rd_req && (mode == MD_BUSY);
   assign array_tick = rd_req && (mode == MD_ARRAY);

   frr_status_tog i_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (st_load),
      .din_i  (st_din),
      .poll_i (busy_poll),
      .stat_o (stat_q)
   );

   frr_fast_mon #(.THRESH(FAST_THRESH)) i_fast (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (wr_seen),
      .tick_i (array_tick),
      .fast_o (fast_rd)
   );

   always_comb begin
      sel_data = arr_word;
      case (mode)
         MD_IDENT: begin
            case (q_idx)
               8'h00: sel_data = {16'h0000, ID0};
               8'h01: sel_data = {16'h0000, ID1};
               8'h02: sel_data = 32'h0;
               8'h0E: if (ID2 != ID_ABSENT) sel_data = {16'h0000, ID2};
               8'h0F: if (ID3 != ID_ABSENT) sel_data = {16'h0000, ID3};
               default: sel_data = arr_word;
            endcase
         end
         MD_BUSY:  sel_data = {24'h0, stat_q};
         MD_QUERY: sel_data = (q_idx >= QRY_TABLE_LEN) ? 32'h0 : {24'h0, cfi_byte};
         default:  sel_data = arr_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 32'h0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= sel_data;
      end
   end

endmodule

// File: rtl/frr_read_resp_chk.sv
module frr_read_resp_chk #(
   parameter int BUS_BYTES = 1,
   parameter int OFF_W     = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic [OFF_W-1:0] rd_off,
   input logic [2:0]       mode,
   input logic             wr_seen,
   input logic             st_load,
   input logic [7:0]       st_din,
   input logic             rd_valid,
   input logic [31:0]      rd_data,
   input logic             fast_rd,
   input logic [7:0]       stat_q
);
   localparam int SH = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;

   logic [7:0] ci;
   always_comb ci = rd_off[7:0] >> SH;

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   assert_unprotected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == 3'd2 && ci == 8'h02) |=> (rd_data == 32'h0));
   assert_poll_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == 3'd3) |=> (rd_data == {24'h0, $past(stat_q)}));
   assert_poll_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == 3'd3 && !st_load) |=> (stat_q == ($past(stat_q) ^ 8'h40)));
   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_load |=> (stat_q == $past(st_din)));
   assert_query_oob_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode == 3'd4 && ci >= 8'h52) |=> (rd_data == 32'h0));
   assert_write_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |=> !fast_rd);

endmodule

bind frr_read_resp frr_read_resp_chk #(.BUS_BYTES(BUS_BYTES), .OFF_W(OFF_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req   (rd_req),
   .rd_off   (rd_off),
   .mode     (mode),
   .wr_seen  (wr_seen),
   .st_load  (st_load),
   .st_din   (st_din),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .fast_rd  (fast_rd),
   .stat_q   (stat_q)
);

// File: tb/test_frr_read_resp.sv
module test_frr_read_resp;
   localparam int CHIP = 4096;
   localparam int AW   = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rd_req;
   logic [AW-1:0] rd_off;
   logic [1:0]    rd_size;
   logic          big_end;
   logic [2:0]    mode;
   logic          wr_seen;
   logic          st_load;
   logic [7:0]    st_din;
   logic [AW-1:0] arr_addr;
   logic [31:0]   arr_rdata;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic          fast_rd;

   always #5 clk = ~clk;

   frr_read_resp #(
      .BUS_BYTES(2), .SECT_BYTES(512), .NUM_SECT(8),
      .ID0(16'h0001), .ID1(16'h2210), .ID2(16'h00FF), .ID3(16'h227E),
      .FAST_THRESH(42)
   ) i_frr_read_resp (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_off(rd_off),
      .rd_size(rd_size), .big_end(big_end), .mode(mode), .wr_seen(wr_seen),
      .st_load(st_load), .st_din(st_din), .arr_addr(arr_addr),
      .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .fast_rd(fast_rd)
   );

   logic [7:0] mem [CHIP];
   assign arr_rdata = {mem[arr_addr + AW'(3)], mem[arr_addr + AW'(2)],
                       mem[arr_addr + AW'(1)], mem[arr_addr]};

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          exp_valid;
   logic [31:0] exp_data;
   string       exp_tag;
   bit          m_flag;
   logic [7:0]  m_stat;
   int          m_cnt;
   bit          be_cfg;

   function automatic logic [31:0] arr_model(logic [AW-1:0] off, logic [1:0] sz);
      int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      logic [31:0] v = 32'h0;
      for (int k = 0; k < n; k++) begin
         logic [7:0] b = mem[(int'(off) + k) % CHIP];
         v |= be_cfg ? (32'(b) << (8 * (n - 1 - k))) : (32'(b) << (8 * k));
      end
      return v;
   endfunction

   function automatic logic [7:0] cfi_model(int i);
      case (i)
         'h10: return 8'h51;
         'h11: return 8'h52;
         'h12: return 8'h59;
         'h13: return 8'h02;
         'h15: return 8'h31;
         'h27: return 8'd12;
         'h2C: return 8'h01;
         'h2D: return 8'h07;
         'h2F: return 8'h02;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] model_read(logic [2:0] md, logic [AW-1:0] off, logic [1:0] sz);
      int idx = int'(off[7:0]) >> 1;
      case (md)
         3'd2: begin
            if (idx == 0)       return 32'h0001;
            else if (idx == 1)  return 32'h2210;
            else if (idx == 2)  return 32'h0;
            else if (idx == 15) return 32'h227E;
            else                return arr_model(off, sz);
         end
         3'd3: return {24'h0, m_stat};
         3'd4: return (idx >= 'h52) ? 32'h0 : {24'h0, cfi_model(idx)};
         default: return arr_model(off, sz);
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit req, logic [AW-1:0] off, logic [1:0] sz, logic [2:0] md,
                      bit wr, bit ld, logic [7:0] ldv, string tag);
      @(negedge clk);
      chk("R2 valid", 32'(rd_valid), 32'(exp_valid));
      if (exp_valid) chk(exp_tag, rd_data, exp_data);
      chk("R11 fast flag", 32'(fast_rd), 32'(m_flag));
      rd_req = req; rd_off = off; rd_size = sz; mode = md;
      wr_seen = wr; st_load = ld; st_din = ldv; big_end = be_cfg;
      if (req) begin
         exp_data = model_read(md, off, sz);
         exp_tag  = tag;
      end
      exp_valid = req;
      if (ld) m_stat = ldv;
      else if (req && md == 3'd3) m_stat ^= 8'h40;
      if (wr) begin
         m_cnt = 0; m_flag = 0;
      end else if (req && md == 3'd0 && !m_flag) begin
         m_cnt++;
         if (m_cnt == 42) m_flag = 1;
      end
   endtask

   task automatic rd(logic [2:0] md, logic [AW-1:0] off, logic [1:0] sz, string tag);
      cyc(1'b1, off, sz, md, 1'b0, 1'b0, 8'h00, tag);
   endtask

   task automatic idle();
      cyc(1'b0, '0, 2'd0, 3'd0, 1'b0, 1'b0, 8'h00, "idle");
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < CHIP; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
      rst_n = 1'b0; rd_req = 0; rd_off = '0; rd_size = 0; big_end = 0;
      mode = 0; wr_seen = 0; st_load = 0; st_din = 0;
      be_cfg = 0; exp_valid = 0; m_flag = 1; m_stat = 0; m_cnt = 0; exp_tag = "";
      repeat (3) @(negedge clk);
      chk("R1 valid", 32'(rd_valid), 32'h0);
      chk("R1 data", rd_data, 32'h0);
      chk("R1 fast", 32'(fast_rd), 32'h1);
      rst_n = 1'b1;
      rd(3'd3, 12'h000, 2'd0, "R1 status after reset");
      idle();
      cyc(1'b0, '0, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00, "R11");
      // R3: array modes and unused codes
      rd(3'd0, 12'h000, 2'd0, "R3 read");
      rd(3'd0, 12'h5A3, 2'd0, "R3 read");
      rd(3'd0, 12'hFFF, 2'd0, "R3 read");
      rd(3'd1, 12'h123, 2'd0, "R3 erase armed");
      rd(3'd5, 12'h777, 2'd1, "R3 code5");
      rd(3'd7, 12'h0F0, 2'd2, "R3 code7");
      // R4: sizes and lane order
      for (int e = 0; e < 2; e++) begin
         be_cfg = bit'(e);
         rd(3'd0, 12'h100, 2'd0, "R4 1B");
         rd(3'd0, 12'h101, 2'd1, "R4 2B");
         rd(3'd0, 12'h202, 2'd2, "R4 4B");
         rd(3'd0, 12'h333, 2'd3, "R4 4B code3");
         rd(3'd0, 12'hFFE, 2'd2, "R4 wrap");
      end
      be_cfg = 0;
      // R5 / R6: identification
      rd(3'd2, 12'h000, 2'd1, "R5 id0");
      rd(3'd2, 12'h002, 2'd1, "R5 id1");
      rd(3'd2, 12'h004, 2'd1, "R5 unprotected");
      rd(3'd2, 12'h304, 2'd0, "R5 high offset");
      rd(3'd2, 12'h01C, 2'd0, "R6 id2 absent");
      rd(3'd2, 12'h01E, 2'd1, "R6 id3");
      rd(3'd2, 12'h006, 2'd0, "R6 other");
      rd(3'd2, 12'h0FE, 2'd1, "R6 other");
      // R7 / R8: status polling
      cyc(1'b0, '0, 2'd0, 3'd3, 1'b0, 1'b1, 8'h80, "R8");
      rd(3'd3, 12'h000, 2'd0, "R7 poll");
      rd(3'd3, 12'h010, 2'd2, "R7 poll");
      idle();
      rd(3'd3, 12'h020, 2'd0, "R7 poll");
      rd(3'd3, 12'h000, 2'd0, "R7 poll");
      cyc(1'b1, 12'h000, 2'd0, 3'd3, 1'b0, 1'b1, 8'h25, "R8 collide");
      rd(3'd3, 12'h000, 2'd0, "R8 after load");
      rd(3'd3, 12'h000, 2'd0, "R8 toggled");
      // R9 / R10: query table
      rd(3'd4, 12'h020, 2'd0, "R9 Q");
      rd(3'd4, 12'h022, 2'd0, "R9 R");
      rd(3'd4, 12'h024, 2'd0, "R9 Y");
      rd(3'd4, 12'h026, 2'd0, "R9 cmdset");
      rd(3'd4, 12'h028, 2'd0, "R9 cmdset hi");
      rd(3'd4, 12'h02A, 2'd0, "R9 ext ptr");
      rd(3'd4, 12'h04E, 2'd0, "R9 size");
      rd(3'd4, 12'h058, 2'd0, "R9 regions");
      rd(3'd4, 12'h05A, 2'd0, "R9 count lo");
      rd(3'd4, 12'h05C, 2'd0, "R9 count hi");
      rd(3'd4, 12'h05E, 2'd0, "R9 sect lo");
      rd(3'd4, 12'h060, 2'd0, "R9 sect hi");
      rd(3'd4, 12'h821, 2'd0, "R9 high offset");
      rd(3'd4, 12'h0A4, 2'd0, "R10 0x52");
      rd(3'd4, 12'h0FE, 2'd0, "R10 0x7F");
      // R11: fast-path hint
      cyc(1'b0, '0, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00, "R11");
      for (int i = 0; i < 42; i++) begin
         rd(3'd0, AW'(i * 5), 2'd0, "R11 count");
         if (i % 10 == 3) rd(3'd3, 12'h000, 2'd0, "R11 busy no count");
         if (i % 10 == 7) rd(3'd1, 12'h000, 2'd0, "R11 armed no count");
      end
      rd(3'd0, 12'h010, 2'd0, "R11 held");
      cyc(1'b1, 12'h044, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00, "R11 collide");
      for (int i = 0; i < 41; i++) rd(3'd0, AW'(i), 2'd1, "R11 recount");
      cyc(1'b1, 12'h000, 2'd0, 3'd0, 1'b1, 1'b0, 8'h00, "R11 clear at 41");
      for (int i = 0; i < 42; i++) rd(3'd0, AW'(i * 3), 2'd0, "R11 recount");
      idle();
      idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule